// File: doc/BRIEF.md
# Serial Transmitter with Peer Hold at Frame Boundaries

The block serialises bytes onto an asynchronous line, one 8N1 frame per byte. The line idles high. Each frame is one low start bit, then eight data bits with the least significant bit first, then one high stop bit. A one-byte holding register sits in front of the shift register. Software can therefore queue the next byte while the current one is on the line, and frames follow each other with no idle gap.

A peer raises an active-high hold input when it cannot accept more data. The block synchronises this input and looks at it only when a new frame could start: either while the line is idle, or at the end of a stop bit. A frame that has already begun always runs through its stop bit. While hold is high no start bit is issued, and a queued byte waits unchanged in the holding register until hold falls. An enable input closes the write port. Bytes that were already accepted still go out.

The bit period is CLK_HZ/BAUD clock cycles. The defaults give 230400 baud from a 50 MHz clock.

Top module: `serial_tx_hold`

## Requirements
- R1: Each frame is a low start bit, eight data bits LSB first and a high stop bit. Every bit lasts exactly CLK_HZ/BAUD clock cycles, and the line is high whenever no frame is being sent.
- R2: The write port is valid/ready. `wr_ready` is high exactly when the holding register is empty and `tx_en` is high. A byte is taken on a clock edge where `wr_valid` and `wr_ready` are both high. The source must hold `wr_data` stable while `wr_valid` is high and `wr_ready` is low.
- R3: When hold is low and a byte is queued, its start bit begins on the cycle right after the previous stop bit ends. Consecutive start bits are then exactly 10 bit periods apart.
- R4: A frame already on the line when hold rises is completed through its stop bit, with its data intact.
- R5: While the synchronised hold is high, no start bit is issued. The queued byte stays in the holding register and is sent unchanged after hold falls. Hold must rise at least three clock cycles before a stop bit ends to block the frame that would follow it.
- R6: A write offered while the holding register is full is ignored: `wr_ready` stays low and the queued byte is not replaced.
- R7: `buf_empty` is high exactly when the holding register has room for a byte.
- R8: `tx_idle` is high after reset. It falls on the cycle after any accepted write. It rises when a stop bit ends with no byte ready to start next.
- R9: With `tx_en` low, no write is accepted. The frame on the line and any byte already queued are still sent when hold allows.
- R10: After reset `tx_line` is high, `wr_ready` and `buf_empty` are high, and no frame is sent until a byte is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Write-port enable; when low, new bytes are refused |
| wr_valid | input | 1 | Byte offered on `wr_data` |
| wr_data | input | 8 | Byte to send |
| wr_ready | output | 1 | Holding register can take a byte |
| peer_hold | input | 1 | Asynchronous active-high request from the peer to pause |
| tx_line | output | 1 | Serial output, idles high |
| buf_empty | output | 1 | Holding register empty |
| tx_idle | output | 1 | Shift and holding registers empty, line idle |

## Verification
The bench raises hold in three places: during the start bit, in the middle of the data bits, and late in the stop bit. Each time it checks that exactly the in-flight frame arrives intact and that the queued byte then waits. A design that sampled hold too late would leak one more frame. A design that gated the shifter instead would cut a frame short or garble its data. Back-to-back pairs check that start bits are exactly ten bit periods apart, which an extra idle cycle between frames would break. Other tests refuse a write while the holding register is full, and drop the enable with a byte still queued. A design that overwrote the queued byte would send the wrong data. A design that flushed the queue on disable would lose the second byte.

// File: rtl/stx_pkg.sv
package stx_pkg;
  localparam int DATA_W  = 8;
  localparam int FRAME_W = DATA_W + 2;
  typedef enum logic {ENG_IDLE = 1'b0, ENG_SHIFT = 1'b1} eng_state_t;
endpackage

// File: rtl/stx_sync.sv
module stx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], async_in};
  end

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/stx_holding.sv
module stx_holding #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         wr_valid,
  input  logic [W-1:0] wr_data,
  output logic         wr_ready,
  input  logic         take,
  output logic         full,
  output logic [W-1:0] data
);
  logic         full_q;
  logic [W-1:0] data_q;
  logic         accept;

  assign wr_ready = !full_q && en;
  assign accept   = wr_valid && wr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (take) begin
      full_q <= 1'b0;
    end else if (accept) begin
      full_q <= 1'b1;
      data_q <= wr_data;
    end
  end

  assign full = full_q;
  assign data = data_q;

  // R6
  held_byte_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !take) |=> (full_q && $stable(data_q)));

  // R2
  accept_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> full_q);
endmodule

// File: rtl/stx_shifter.sv
module stx_shifter
  import stx_pkg::*;
#(
  parameter int DIV = 217
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              have_byte,
  input  logic [DATA_W-1:0] byte_in,
  input  logic              hold,
  output logic              take,
  output logic              busy,
  output logic              went_idle,
  output logic              tx
);
  localparam int CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int IDX_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_W - 1);

  eng_state_t         state_q;
  logic [CNT_W-1:0]   baud_q;
  logic [IDX_W-1:0]   idx_q;
  logic [FRAME_W-1:0] shreg_q;
  logic               bit_end;
  logic               last_bit;

  assign busy     = (state_q == ENG_SHIFT);
  assign bit_end  = busy && (baud_q == CNT_LAST);
  assign last_bit = (idx_q == IDX_LAST);
  assign take     = have_byte && !hold && (!busy || (bit_end && last_bit));
  assign went_idle = bit_end && last_bit && !take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      baud_q  <= '0;
      idx_q   <= '0;
      shreg_q <= '1;
    end else if (take) begin
      state_q <= ENG_SHIFT;
      baud_q  <= '0;
      idx_q   <= '0;
      shreg_q <= {1'b1, byte_in, 1'b0};
    end else if (bit_end) begin
      baud_q <= '0;
      if (last_bit) begin
        state_q <= ENG_IDLE;
        shreg_q <= '1;
      end else begin
        idx_q   <= idx_q + 1'b1;
        shreg_q <= {1'b1, shreg_q[FRAME_W-1:1]};
      end
    end else if (busy) begin
      baud_q <= baud_q + 1'b1;
    end
  end

  assign tx = busy ? shreg_q[0] : 1'b1;

  // R4
  no_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bit_end) |=> busy);

  // R1
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && baud_q != '0) |-> $stable(tx));

  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx);
endmodule

// File: rtl/serial_tx_hold.sv
module serial_tx_hold
  import stx_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000,
  parameter int BAUD   = 230_400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  input  logic              peer_hold,
  output logic              tx_line,
  output logic              buf_empty,
  output logic              tx_idle
);
  localparam int DIV = CLK_HZ / BAUD;

  logic              hold_s;
  logic              full;
  logic [DATA_W-1:0] held_byte;
  logic              take;
  logic              busy;
  logic              went_idle;
  logic              idle_q;

  stx_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(peer_hold), .sync_out(hold_s)
  );

  stx_holding #(.W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .en(tx_en),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .take(take), .full(full), .data(held_byte)
  );

  stx_shifter #(.DIV(DIV)) u_eng (
    .clk(clk), .rst_n(rst_n), .have_byte(full), .byte_in(held_byte),
    .hold(hold_s), .take(take), .busy(busy), .went_idle(went_idle),
    .tx(tx_line)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   idle_q <= 1'b1;
    else if (wr_valid && wr_ready) idle_q <= 1'b0;
    else if (went_idle && !full)  idle_q <= 1'b1;
  end

  assign tx_idle   = idle_q;
  assign buf_empty = !full;

  initial begin
    if (DIV < 2) $error("bit period below two clocks");
  end

  // R5
  start_needs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(hold_s));

  // R8
  idle_means_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_idle |-> (!busy && buf_empty));

  // R9
  disabled_refuses_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> !wr_ready);
endmodule

// File: tb/serial_tx_hold_bench.sv
module serial_tx_hold_bench;
  localparam int CLK_HZ = 1_843_200;
  localparam int BAUD   = 230_400;
  localparam int DIV    = CLK_HZ / BAUD;
  localparam int NPAIR  = 4;
  localparam logic [15:0] PAIRS [NPAIR] = '{16'hA53C, 16'h00FF, 16'h817E, 16'h5501};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b1;
  logic wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic peer_hold = 1'b0;
  logic wr_ready, tx_line, buf_empty, tx_idle;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int rx_n = 0;
  logic [7:0] rx_byte [64];
  int rx_start [64];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  serial_tx_hold #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) u_serial_tx_hold (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .wr_valid(wr_valid),
    .wr_data(wr_data), .wr_ready(wr_ready), .peer_hold(peer_hold),
    .tx_line(tx_line), .buf_empty(buf_empty), .tx_idle(tx_idle)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // line monitor: samples each bit in its middle
  initial begin : monitor
    logic prev;
    logic [7:0] b;
    prev = 1'b1;
    forever begin
      @(negedge clk);
      if (rst_n && prev && !tx_line) begin
        rx_start[rx_n % 64] = cyc;
        repeat (DIV/2) @(negedge clk);
        chk(tx_line == 1'b0, "R1 start bit low", tx_line, 0);
        for (int i = 0; i < 8; i++) begin
          repeat (DIV) @(negedge clk);
          b[i] = tx_line;
        end
        repeat (DIV) @(negedge clk);
        chk(tx_line == 1'b1, "R1 stop bit high", tx_line, 1);
        rx_byte[rx_n % 64] = b;
        rx_n = rx_n + 1;
      end
      prev = tx_line;
    end
  end

  task automatic send(input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = d;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000 && !tx_idle; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic hold_case(input int offset, input logic [7:0] b0, input logic [7:0] b1, input string tag);
    int base;
    base = rx_n;
    send(b0);
    send(b1);
    repeat (offset) @(negedge clk);
    peer_hold = 1'b1;
    repeat (14*DIV) @(negedge clk);
    // R4 the in-flight frame finished intact
    chk(rx_n == base + 1, {"R4 one frame after hold ", tag}, rx_n - base, 1);
    chk(rx_byte[base % 64] == b0, {"R4 in-flight byte ", tag}, rx_byte[base % 64], b0);
    // R5 queued byte still waiting, line quiet
    chk(tx_line == 1'b1 && buf_empty == 1'b0, {"R5 held byte waits ", tag}, {tx_line, buf_empty}, 2'b10);
    chk(tx_idle == 1'b0, {"R8 not idle while queued ", tag}, tx_idle, 0);
    peer_hold = 1'b0;
    wait_idle();
    chk(rx_n == base + 2, {"R5 released frame sent ", tag}, rx_n - base, 2);
    chk(rx_byte[(base+1) % 64] == b1, {"R5 held byte unchanged ", tag}, rx_byte[(base+1) % 64], b1);
  endtask

  initial begin : main
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(tx_line == 1'b1, "R10 line high", tx_line, 1);
    chk(wr_ready == 1'b1, "R10 ready", wr_ready, 1);
    chk(buf_empty == 1'b1, "R7 empty after reset", buf_empty, 1);
    chk(tx_idle == 1'b1, "R8 idle after reset", tx_idle, 1);
    repeat (3*DIV) @(negedge clk);
    chk(rx_n == 0, "R10 no spurious frame", rx_n, 0);

    // table of back-to-back pairs
    for (int p = 0; p < NPAIR; p++) begin
      base = rx_n;
      send(PAIRS[p][15:8]);
      chk(tx_idle == 1'b0, "R8 idle clears on write", tx_idle, 0);
      send(PAIRS[p][7:0]);
      wait_idle();
      chk(tx_idle == 1'b1, "R8 idle after last stop", tx_idle, 1);
      chk(rx_n == base + 2, "R1 pair count", rx_n - base, 2);
      chk(rx_byte[base % 64] == PAIRS[p][15:8], "R1 first byte", rx_byte[base % 64], PAIRS[p][15:8]);
      chk(rx_byte[(base+1) % 64] == PAIRS[p][7:0], "R1 second byte", rx_byte[(base+1) % 64], PAIRS[p][7:0]);
      chk(rx_start[(base+1) % 64] - rx_start[base % 64] == 10*DIV, "R3 no gap",
          rx_start[(base+1) % 64] - rx_start[base % 64], 10*DIV);
    end

    // hold at several points within the frame
    hold_case(0, 8'h96, 8'h69, "start");
    hold_case(3*DIV, 8'hC3, 8'h3C, "data");
    hold_case(9*DIV, 8'hF0, 8'h0F, "stop");

    // hold while idle, plus write while full
    base = rx_n;
    peer_hold = 1'b1;
    repeat (4) @(negedge clk);
    send(8'h5A);
    chk(buf_empty == 1'b0, "R7 full after write", buf_empty, 0);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = 8'hEE;
    repeat (5) @(negedge clk);
    chk(wr_ready == 1'b0, "R6 ready low while full", wr_ready, 0);
    wr_valid = 1'b0;
    repeat (20*DIV) @(negedge clk);
    chk(rx_n == base, "R5 no start while held idle", rx_n - base, 0);
    peer_hold = 1'b0;
    wait_idle();
    repeat (12*DIV) @(negedge clk);
    chk(rx_n == base + 1, "R6 only one frame", rx_n - base, 1);
    chk(rx_byte[base % 64] == 8'h5A, "R6 queued byte kept", rx_byte[base % 64], 8'h5A);

    // disable with a byte queued
    base = rx_n;
    send(8'h12);
    send(8'h34);
    tx_en = 1'b0;
    @(negedge clk);
    chk(wr_ready == 1'b0, "R9 refused when disabled", wr_ready, 0);
    wr_valid = 1'b1;
    wr_data  = 8'h77;
    repeat (10) @(negedge clk);
    wr_valid = 1'b0;
    wait_idle();
    repeat (12*DIV) @(negedge clk);
    chk(rx_n == base + 2, "R9 pending bytes still sent", rx_n - base, 2);
    chk(rx_byte[(base+1) % 64] == 8'h34, "R9 queued byte sent", rx_byte[(base+1) % 64], 8'h34);
    chk(wr_ready == 1'b0 && buf_empty == 1'b1, "R2 ready needs enable", {wr_ready, buf_empty}, 2'b01);
    tx_en = 1'b1;
    @(negedge clk);
    chk(wr_ready == 1'b1, "R2 ready back with enable", wr_ready, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule